// File: doc/BRIEF.md
# Sleep and Wake Mode Controller

This block holds the power mode of a multi-input switch monitor: Normal, in which registers may be written, or Sleep, in which the monitor waits for a wake-up. A power-on reset puts it in Normal. A sleep command strobe from the command decoder moves it to Sleep. A set of qualified wake sources returns it to Normal. Each wake source also produces a one-cycle wake pulse.

The wake sources are a falling edge on the dedicated wake pin, a switch change-of-state on an input whose wake enable is set, and an interrupt-timer expiry. Two more sources count only when the logic supply is present: a falling edge on the interrupt pin, which also needs the wake pin to be high, and a falling edge on the chip-select pin. The three pins are asynchronous. Each one passes through a two-flop synchronizer, and a falling edge is found by comparing the synchronized level with its value one cycle earlier. Losing the logic supply never changes the mode by itself. It only removes write permission and disables the two supply-qualified pin sources.

Top module: `slp_mode_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the mode is Normal (`mode_sleep` = 0) and `wake_pulse` is 0.
- R2: A `sleep_req` strobe in Normal, with no wake event in the same cycle, sets `mode_sleep` to 1 at the next rising clock edge. A strobe in Sleep has no effect.
- R3: A falling edge on `wake_pin` wakes the block whatever the state of `supply_ok`. `mode_sleep` drops at the third rising edge after the pin goes low: two synchronizer stages, then the edge compare.
- R4: A 1 on `sw_change[i]` wakes the block at the next edge only when `wake_en[i]` is 1. When `wake_en[i]` is 0 it has no effect.
- R5: A 1 on `tmr_expired` wakes the block at the next rising edge.
- R6: A falling edge on `irq_pin` wakes the block, with the same three-edge latency as R3, only while `supply_ok` is 1 and the synchronized `wake_pin` is 1.
- R7: A falling edge on `sel_pin` wakes the block, with the same latency as R3, only while `supply_ok` is 1.
- R8: A change of `supply_ok` alone never changes the mode, in Normal or in Sleep.
- R9: `reg_write_ok` is 1 exactly when the mode is Normal and `supply_ok` is 1.
- R10: Each qualified wake event raises `wake_pulse` for exactly one cycle, registered, in either mode.
- R11: When a wake event and a `sleep_req` fall in the same cycle, the block ends that cycle in Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| sleep_req | input | 1 | Sleep command strobe, one cycle |
| supply_ok | input | 1 | Logic supply present |
| wake_pin | input | 1 | Asynchronous wake pin, idle high |
| irq_pin | input | 1 | Asynchronous interrupt pin, idle high |
| sel_pin | input | 1 | Asynchronous chip-select pin, idle high |
| wake_en | input | N_SW | Per-input wake enables |
| sw_change | input | N_SW | Per-input change-of-state flags |
| tmr_expired | input | 1 | Interrupt timer expiry pulse |
| mode_sleep | output | 1 | 1 = Sleep, 0 = Normal |
| reg_write_ok | output | 1 | Register writes permitted |
| wake_pulse | output | 1 | One-cycle pulse per qualified wake event |

## Verification
Each wake source is tried twice: once with its qualifiers met, and again with one qualifier removed. The removed qualifier is the supply for the chip-select and interrupt pins, the wake-pin level for the interrupt pin, and the enable bit for a switch change. This separates correct qualification from a source that is always honoured or always ignored. The supply is dropped in both modes, which separates "mode frozen" from "mode forced". A sleep strobe is applied in Sleep, and again together with a timer expiry in Normal, to exercise the ignore rule and the wake-wins priority. Pin edges are sampled exactly three edges after the stimulus, so any error in synchronizer depth shows up.

// File: rtl/slp_pkg.sv
package slp_pkg;
    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_SLEEP  = 1'b1
    } mode_t;

    localparam int PIN_WAKE = 0;
    localparam int PIN_IRQ  = 1;
    localparam int PIN_SEL  = 2;
    localparam int N_PIN    = 3;
endpackage

// File: rtl/slp_edge_det.sv
module slp_edge_det #(
    parameter int N_IN = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] pin_async,
    output logic [N_IN-1:0] level,
    output logic [N_IN-1:0] fall
);
    typedef struct packed {
        logic [N_IN-1:0] meta;
        logic [N_IN-1:0] sync;
        logic [N_IN-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_async;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{meta: '1, sync: '1, prev: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.sync;
    assign fall  = st_q.prev & ~st_q.sync;

    generate
        for (genvar g = 0; g < N_IN; g++) begin : g_chk
            // R3
            fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
                fall[g] |=> !fall[g]);
        end
    endgenerate
endmodule

// File: rtl/slp_wake_qual.sv
module slp_wake_qual
    import slp_pkg::*;
#(
    parameter int N_SW = 8
) (
    input  logic [N_PIN-1:0] pin_fall,
    input  logic [N_PIN-1:0] pin_level,
    input  logic             supply_ok,
    input  logic [N_SW-1:0]  wake_en,
    input  logic [N_SW-1:0]  sw_change,
    input  logic             tmr_expired,
    output logic             wake_evt
);
    logic src_wake, src_irq, src_sel, src_sw;

    always_comb begin
        src_wake = pin_fall[PIN_WAKE];
        src_irq  = pin_fall[PIN_IRQ] & supply_ok & pin_level[PIN_WAKE];
        src_sel  = pin_fall[PIN_SEL] & supply_ok;
        src_sw   = |(sw_change & wake_en);
        wake_evt = src_wake | src_irq | src_sel | src_sw | tmr_expired;
    end
endmodule

// File: rtl/slp_mode_ctrl.sv
module slp_mode_ctrl
    import slp_pkg::*;
#(
    parameter int N_SW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req,
    input  logic            supply_ok,
    input  logic            wake_pin,
    input  logic            irq_pin,
    input  logic            sel_pin,
    input  logic [N_SW-1:0] wake_en,
    input  logic [N_SW-1:0] sw_change,
    input  logic            tmr_expired,
    output logic            mode_sleep,
    output logic            reg_write_ok,
    output logic            wake_pulse
);
    typedef struct packed {
        mode_t mode;
        logic  pulse;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic [N_PIN-1:0] pins, pin_level, pin_fall;
    logic             wake_evt;

    always_comb begin
        pins           = '0;
        pins[PIN_WAKE] = wake_pin;
        pins[PIN_IRQ]  = irq_pin;
        pins[PIN_SEL]  = sel_pin;
    end

    slp_edge_det #(.N_IN(N_PIN)) i_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pins),
        .level     (pin_level),
        .fall      (pin_fall)
    );

    slp_wake_qual #(.N_SW(N_SW)) i_qual (
        .pin_fall    (pin_fall),
        .pin_level   (pin_level),
        .supply_ok   (supply_ok),
        .wake_en     (wake_en),
        .sw_change   (sw_change),
        .tmr_expired (tmr_expired),
        .wake_evt    (wake_evt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = wake_evt;
        if (wake_evt) begin
            st_d.mode = MODE_NORMAL;
        end else if (sleep_req && st_q.mode == MODE_NORMAL) begin
            st_d.mode = MODE_SLEEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_NORMAL, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_sleep   = (st_q.mode == MODE_SLEEP);
    assign reg_write_ok = (st_q.mode == MODE_NORMAL) && supply_ok;
    assign wake_pulse   = st_q.pulse;

    // R2
    sleep_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sleep && sleep_req && !wake_evt) |=> mode_sleep);

    // R11
    wake_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> (!mode_sleep && wake_pulse));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_evt && !sleep_req) |=> $stable(mode_sleep));

    // R9
    no_write_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sleep |-> !reg_write_ok);

    // R10
    pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_evt |=> !wake_pulse);
endmodule

// File: tb/test_slp_mode_ctrl.sv
module test_slp_mode_ctrl;
    localparam int N_SW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sleep_req = 1'b0;
    logic            supply_ok = 1'b1;
    logic            wake_pin = 1'b1;
    logic            irq_pin = 1'b1;
    logic            sel_pin = 1'b1;
    logic [N_SW-1:0] wake_en = '0;
    logic [N_SW-1:0] sw_change = '0;
    logic            tmr_expired = 1'b0;
    logic            mode_sleep, reg_write_ok, wake_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    slp_mode_ctrl #(.N_SW(N_SW)) i_slp_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .supply_ok(supply_ok),
        .wake_pin(wake_pin), .irq_pin(irq_pin), .sel_pin(sel_pin),
        .wake_en(wake_en), .sw_change(sw_change), .tmr_expired(tmr_expired),
        .mode_sleep(mode_sleep), .reg_write_ok(reg_write_ok), .wake_pulse(wake_pulse)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic go_sleep();
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 mode", mode_sleep, 1'b0);
        check("R1 pulse", wake_pulse, 1'b0);
        rst_n = 1'b1;
        step(2);
        check("R1 mode after release", mode_sleep, 1'b0);
        check("R9 write ok in normal", reg_write_ok, 1'b1);
    endtask

    task automatic t_sleep_cmd();
        go_sleep();
        check("R2 enter sleep", mode_sleep, 1'b1);
        check("R9 no write in sleep", reg_write_ok, 1'b0);
        go_sleep();
        check("R2 strobe in sleep", mode_sleep, 1'b1);
        check("R2 no pulse", wake_pulse, 1'b0);
    endtask

    task automatic t_wake_pin();
        wake_pin = 1'b0;
        step(2);
        check("R3 not before third edge", mode_sleep, 1'b1);
        step();
        check("R3 wake pin wakes", mode_sleep, 1'b0);
        check("R10 pulse high", wake_pulse, 1'b1);
        step();
        check("R10 pulse one cycle", wake_pulse, 1'b0);
        wake_pin = 1'b1;
        step(4);
        check("R10 no pulse on rise", wake_pulse, 1'b0);
    endtask

    task automatic t_switch();
        go_sleep();
        wake_en = 8'b0000_0100;
        sw_change = 8'b0000_1000;
        step();
        sw_change = '0;
        check("R4 disabled input ignored", mode_sleep, 1'b1);
        sw_change = 8'b0000_0100;
        step();
        sw_change = '0;
        check("R4 enabled input wakes", mode_sleep, 1'b0);
        wake_en = '0;
    endtask

    task automatic t_timer();
        go_sleep();
        tmr_expired = 1'b1;
        step();
        tmr_expired = 1'b0;
        check("R5 timer wakes", mode_sleep, 1'b0);
        check("R10 timer pulse", wake_pulse, 1'b1);
    endtask

    task automatic t_irq();
        go_sleep();
        irq_pin = 1'b0;
        step(3);
        check("R6 irq wakes", mode_sleep, 1'b0);
        irq_pin = 1'b1;
        step(4);
        // wake pin low first, settle in normal, then sleep
        wake_pin = 1'b0;
        step(4);
        go_sleep();
        irq_pin = 1'b0;
        step(4);
        check("R6 irq ignored with wake low", mode_sleep, 1'b1);
        irq_pin = 1'b1;
        step(3);
        supply_ok = 1'b0;
        wake_pin = 1'b1;
        step(4);
        irq_pin = 1'b0;
        step(4);
        check("R6 irq ignored without supply", mode_sleep, 1'b1);
        irq_pin = 1'b1;
        supply_ok = 1'b1;
        step(4);
    endtask

    task automatic t_sel();
        supply_ok = 1'b0;
        sel_pin = 1'b0;
        step(4);
        check("R7 sel ignored without supply", mode_sleep, 1'b1);
        sel_pin = 1'b1;
        supply_ok = 1'b1;
        step(4);
        sel_pin = 1'b0;
        step(3);
        check("R7 sel wakes", mode_sleep, 1'b0);
        sel_pin = 1'b1;
        step(4);
    endtask

    task automatic t_supply();
        supply_ok = 1'b0;
        step(2);
        check("R8 normal held", mode_sleep, 1'b0);
        check("R9 no write without supply", reg_write_ok, 1'b0);
        go_sleep();
        supply_ok = 1'b1;
        step(2);
        supply_ok = 1'b0;
        step(2);
        check("R8 sleep held", mode_sleep, 1'b1);
        wake_pin = 1'b0;
        step(3);
        check("R3 wake pin without supply", mode_sleep, 1'b0);
        wake_pin = 1'b1;
        supply_ok = 1'b1;
        step(4);
        check("R9 write ok restored", reg_write_ok, 1'b1);
    endtask

    task automatic t_priority();
        sleep_req = 1'b1;
        tmr_expired = 1'b1;
        step();
        sleep_req = 1'b0;
        tmr_expired = 1'b0;
        check("R11 wake beats sleep", mode_sleep, 1'b0);
        check("R10 pulse in normal", wake_pulse, 1'b1);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(2);
        t_reset();
        t_sleep_cmd();
        t_wake_pin();
        t_switch();
        t_timer();
        t_irq();
        t_sel();
        t_supply();
        t_priority();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule